// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block translates 32-bit virtual addresses with 4 KB pages into physical addresses. Each request carries a virtual address, a 6-bit address space tag, an access kind (read, write or fetch) and a flag that marks user mode. The three most significant address bits choose a region. Two kernel regions skip translation and map straight onto physical memory: one is cached and one is uncached. Every other address is looked up in a 64-entry fully associative table. The response reports exactly one of four outcomes: hit, refill miss, write-protection fault or address error. It arrives one clock after the request.

Table entries are loaded only by software, through a fill port that writes one whole entry at an index the caller chooses. Every entry is tagged with an address space identifier. Translations that belong to different processes can therefore stay resident together, and a context switch needs no flush. No page table is walked in hardware. A refill miss is handed back to the caller, which is expected to install the entry and retry.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, rsp_valid and every outcome flag are low, and all 64 entries are invalid. Any translated lookup made before the first fill therefore reports rsp_miss.
- R2: A request with req_valid high in one cycle yields rsp_valid high in the next cycle. While rsp_valid is high, exactly one of rsp_hit, rsp_miss, rsp_prot_fault and rsp_addr_err is high.
- R3: On a translated hit, rsp_pa[11:0] equals req_va[11:0] and rsp_pa[31:12] equals the frame number stored in the matching entry.
- R4: A table hit needs the entry's page number to equal req_va[31:12] and its identifier to equal req_asid. The same page number under a different identifier reports rsp_miss.
- R5: Region decode uses req_va[31:29]. Values 0xx and 11x are translated. The value 100 is direct-mapped and cached, and 101 is direct-mapped and uncached. A kernel access to a direct region reports rsp_hit with rsp_pa equal to req_va with bits 31:29 cleared. In that case rsp_uncached is high only for 101.
- R6: A tag match on an entry whose present bit is clear reports rsp_miss, not a hit.
- R7: A user-mode request with req_va[31] high reports rsp_addr_err, whatever the table holds.
- R8: A user-mode access that matches an entry whose user bit is clear reports rsp_addr_err. A kernel-mode access to the same entry hits.
- R9: req_kind is encoded as 00 read, 01 write and 10 fetch, and 11 behaves as a read. A write that matches a present entry whose writable bit is clear reports rsp_prot_fault and never rsp_hit. A read or a fetch to that entry hits.
- R10: On a translated hit, rsp_uncached equals the cache-disable bit of the matching entry.
- R11: With fill_en high, the fill port writes page number, identifier, frame and the four flag bits at fill_idx in one cycle. A lookup in the same cycle sees the previous contents, and a later lookup sees the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 32 | Virtual address |
| req_asid | input | 6 | Address space identifier of the request |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| req_user | input | 1 | High for a user-mode access |
| fill_en | input | 1 | Write one entry this cycle |
| fill_idx | input | 6 | Entry index to write |
| fill_vpn | input | 20 | Virtual page number for the entry |
| fill_asid | input | 6 | Identifier for the entry |
| fill_pfn | input | 20 | Physical frame number for the entry |
| fill_present | input | 1 | Present bit |
| fill_writable | input | 1 | Writable bit |
| fill_user | input | 1 | User-accessible bit |
| fill_nocache | input | 1 | Cache-disable bit |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_pa | output | 32 | Physical address (zero unless rsp_hit) |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No present entry matched, software refill needed |
| rsp_prot_fault | output | 1 | Write to a read-only page |
| rsp_addr_err | output | 1 | User access to kernel space or to a kernel page |
| rsp_uncached | output | 1 | The physical access must bypass the cache |

## Verification
A software fill and a lookup can land in the same cycle, and that can include the very index the lookup needs. The bench provokes this by driving a fill that rewrites an existing entry with a new page number, and by presenting a lookup of the new page in the same cycle. The response is judged correct if it is a miss that reflects the old contents. A lookup of the new page in the next cycle must then hit with the new frame, and the old page must miss.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   typedef enum logic [1:0] {
      KIND_READ  = 2'b00,
      KIND_WRITE = 2'b01,
      KIND_FETCH = 2'b10,
      KIND_RSVD  = 2'b11
   } acc_kind_e;

   typedef enum logic [1:0] {
      SEG_USER_MAPPED,
      SEG_KERN_DIRECT_CACHED,
      SEG_KERN_DIRECT_UNCACHED,
      SEG_KERN_MAPPED
   } region_e;

   localparam int REGION_BITS = 3;

endpackage

// File: rtl/tlb_region_dec.sv
module tlb_region_dec
   import tlb_pkg::*;
(
   input  logic [REGION_BITS-1:0] top_bits,
   output region_e                region,
   output logic                   translated
);

   always_comb begin
      if (!top_bits[2])
         region = SEG_USER_MAPPED;
      else if (top_bits[1])
         region = SEG_KERN_MAPPED;
      else if (top_bits[0])
         region = SEG_KERN_DIRECT_UNCACHED;
      else
         region = SEG_KERN_DIRECT_CACHED;
   end

   assign translated = (region == SEG_USER_MAPPED) || (region == SEG_KERN_MAPPED);

endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
   parameter int ENTRIES = 64,
   parameter int VPN_W   = 20,
   parameter int ASID_W  = 6,
   parameter int PFN_W   = 20,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic [PFN_W-1:0]  wr_pfn,
   input  logic              wr_present,
   input  logic              wr_writable,
   input  logic              wr_user,
   input  logic              wr_nocache,
   input  logic [VPN_W-1:0]  look_vpn,
   input  logic [ASID_W-1:0] look_asid,
   output logic              found,
   output logic [PFN_W-1:0]  hit_pfn,
   output logic              hit_present,
   output logic              hit_writable,
   output logic              hit_user,
   output logic              hit_nocache
);

   typedef struct packed {
      logic [VPN_W-1:0]  vpn;
      logic [ASID_W-1:0] asid;
      logic [PFN_W-1:0]  pfn;
      logic              present;
      logic              writable;
      logic              user;
      logic              nocache;
   } slot_t;

   slot_t             slots [ENTRIES];
   logic [ENTRIES-1:0] match_vec;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            slots[i] <= '0;
         else if (wr_en && (wr_idx == IDX_W'(i)))
            slots[i] <= '{vpn: wr_vpn, asid: wr_asid, pfn: wr_pfn, present: wr_present,
                          writable: wr_writable, user: wr_user, nocache: wr_nocache};
      end
      assign match_vec[i] = (slots[i].vpn == look_vpn) && (slots[i].asid == look_asid);
   end

   // lowest matching index wins if software ever leaves duplicates
   always_comb begin
      found        = |match_vec;
      hit_pfn      = '0;
      hit_present  = 1'b0;
      hit_writable = 1'b0;
      hit_user     = 1'b0;
      hit_nocache  = 1'b0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match_vec[i]) begin
            hit_pfn      = slots[i].pfn;
            hit_present  = slots[i].present;
            hit_writable = slots[i].writable;
            hit_user     = slots[i].user;
            hit_nocache  = slots[i].nocache;
         end
      end
   end

   // R11: a fill is visible in the slot one cycle later
   assert_fill_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (slots[$past(wr_idx)].vpn == $past(wr_vpn)) &&
                (slots[$past(wr_idx)].pfn == $past(wr_pfn)));

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
   import tlb_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int PAGE_BITS = 12,
   parameter int ASID_W    = 6,
   parameter int ENTRIES   = 64,
   localparam int VPN_W    = VA_W - PAGE_BITS,
   localparam int IDX_W    = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [VA_W-1:0]   req_va,
   input  logic [ASID_W-1:0] req_asid,
   input  logic [1:0]        req_kind,
   input  logic              req_user,
   input  logic              fill_en,
   input  logic [IDX_W-1:0]  fill_idx,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [ASID_W-1:0] fill_asid,
   input  logic [VPN_W-1:0]  fill_pfn,
   input  logic              fill_present,
   input  logic              fill_writable,
   input  logic              fill_user,
   input  logic              fill_nocache,
   output logic              rsp_valid,
   output logic [VA_W-1:0]   rsp_pa,
   output logic              rsp_hit,
   output logic              rsp_miss,
   output logic              rsp_prot_fault,
   output logic              rsp_addr_err,
   output logic              rsp_uncached
);

   if (VPN_W < REGION_BITS) begin : g_bad_split
      $error("page number narrower than region field");
   end
   if (ENTRIES < 2) begin : g_bad_depth
      $error("table needs at least two entries");
   end

   region_e            region;
   logic               translated;
   logic               found, e_present, e_writable, e_user, e_nocache;
   logic [VPN_W-1:0]   e_pfn;
   logic [PAGE_BITS-1:0] offset;

   assign offset = req_va[PAGE_BITS-1:0];

   tlb_region_dec u_dec (
      .top_bits   (req_va[VA_W-1 -: REGION_BITS]),
      .region     (region),
      .translated (translated)
   );

   tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(VPN_W)) u_cam (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (fill_en),
      .wr_idx       (fill_idx),
      .wr_vpn       (fill_vpn),
      .wr_asid      (fill_asid),
      .wr_pfn       (fill_pfn),
      .wr_present   (fill_present),
      .wr_writable  (fill_writable),
      .wr_user      (fill_user),
      .wr_nocache   (fill_nocache),
      .look_vpn     (req_va[VA_W-1:PAGE_BITS]),
      .look_asid    (req_asid),
      .found        (found),
      .hit_pfn      (e_pfn),
      .hit_present  (e_present),
      .hit_writable (e_writable),
      .hit_user     (e_user),
      .hit_nocache  (e_nocache)
   );

   logic            n_hit, n_miss, n_prot, n_aerr, n_unc;
   logic [VA_W-1:0] n_pa;

   always_comb begin
      n_hit  = 1'b0;
      n_miss = 1'b0;
      n_prot = 1'b0;
      n_aerr = 1'b0;
      n_unc  = 1'b0;
      n_pa   = '0;
      if (req_user && req_va[VA_W-1]) begin
         n_aerr = 1'b1;
      end else if (!translated) begin
         n_hit = 1'b1;
         n_pa  = {{REGION_BITS{1'b0}}, req_va[VA_W-REGION_BITS-1:0]};
         n_unc = (region == SEG_KERN_DIRECT_UNCACHED);
      end else if (!found || !e_present) begin
         n_miss = 1'b1;
      end else if (req_user && !e_user) begin
         n_aerr = 1'b1;
      end else if ((req_kind == KIND_WRITE) && !e_writable) begin
         n_prot = 1'b1;
      end else begin
         n_hit = 1'b1;
         n_pa  = {e_pfn, offset};
         n_unc = e_nocache;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid      <= 1'b0;
         rsp_pa         <= '0;
         rsp_hit        <= 1'b0;
         rsp_miss       <= 1'b0;
         rsp_prot_fault <= 1'b0;
         rsp_addr_err   <= 1'b0;
         rsp_uncached   <= 1'b0;
      end else begin
         rsp_valid      <= req_valid;
         rsp_pa         <= req_valid ? n_pa : '0;
         rsp_hit        <= req_valid & n_hit;
         rsp_miss       <= req_valid & n_miss;
         rsp_prot_fault <= req_valid & n_prot;
         rsp_addr_err   <= req_valid & n_aerr;
         rsp_uncached   <= req_valid & n_unc;
      end
   end

   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_single_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_prot_fault, rsp_addr_err}) == 1);

   assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> rsp_pa[PAGE_BITS-1:0] == $past(req_va[PAGE_BITS-1:0]));

   assert_uncached_on_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_uncached |-> rsp_hit);

   assert_user_kernel_seg_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_user && req_va[VA_W-1]) |=> rsp_addr_err);

endmodule

// File: tb/sim_tlb_xlate.sv
`timescale 1ns/1ps
module sim_tlb_xlate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_va = '0;
   logic [5:0]  req_asid = '0;
   logic [1:0]  req_kind = '0;
   logic        req_user = 1'b0;
   logic        fill_en = 1'b0;
   logic [5:0]  fill_idx = '0;
   logic [19:0] fill_vpn = '0;
   logic [5:0]  fill_asid = '0;
   logic [19:0] fill_pfn = '0;
   logic        fill_present = 1'b0, fill_writable = 1'b0, fill_user = 1'b0, fill_nocache = 1'b0;
   logic        rsp_valid, rsp_hit, rsp_miss, rsp_prot_fault, rsp_addr_err, rsp_uncached;
   logic [31:0] rsp_pa;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   tlb_xlate u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va), .req_asid(req_asid),
      .req_kind(req_kind), .req_user(req_user), .fill_en(fill_en), .fill_idx(fill_idx),
      .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_pfn(fill_pfn),
      .fill_present(fill_present), .fill_writable(fill_writable), .fill_user(fill_user),
      .fill_nocache(fill_nocache), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_hit(rsp_hit),
      .rsp_miss(rsp_miss), .rsp_prot_fault(rsp_prot_fault), .rsp_addr_err(rsp_addr_err),
      .rsp_uncached(rsp_uncached)
   );

   // flags packed as {valid, hit, miss, prot, aerr, uncached}
   task automatic expect_rsp(input string req, input logic [5:0] exp_f, input logic [31:0] exp_pa);
      logic [5:0] act_f;
      act_f = {rsp_valid, rsp_hit, rsp_miss, rsp_prot_fault, rsp_addr_err, rsp_uncached};
      vectors++;
      if (act_f !== exp_f || rsp_pa !== exp_pa) begin
         errors++;
         $display("FAIL %s: flags=%b pa=%h expected flags=%b pa=%h", req, act_f, rsp_pa, exp_f, exp_pa);
      end
   endtask

   task automatic do_fill(input logic [5:0] idx, input logic [19:0] vpn, input logic [5:0] asid,
                          input logic [19:0] pfn, input logic [3:0] pwun);
      @(negedge clk);
      fill_en = 1'b1; fill_idx = idx; fill_vpn = vpn; fill_asid = asid; fill_pfn = pfn;
      {fill_present, fill_writable, fill_user, fill_nocache} = pwun;
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   task automatic lookup(input logic [31:0] va, input logic [5:0] asid, input logic [1:0] kind,
                         input logic user);
      @(negedge clk);
      req_valid = 1'b1; req_va = va; req_asid = asid; req_kind = kind; req_user = user;
      @(negedge clk);
      req_valid = 1'b0;
      fill_en   = 1'b0;
   endtask

   localparam logic [5:0] F_HIT  = 6'b110000;
   localparam logic [5:0] F_HITU = 6'b110001;
   localparam logic [5:0] F_MISS = 6'b101000;
   localparam logic [5:0] F_PROT = 6'b100100;
   localparam logic [5:0] F_AERR = 6'b100010;

   task automatic t_reset();
      expect_rsp("R1 idle after reset", 6'b000000, 32'h0);
      lookup(32'h0000_1234, 6'd0, 2'b00, 1'b0);
      expect_rsp("R1 empty table misses", F_MISS, 32'h0);
      lookup(32'hC000_0000, 6'd0, 2'b10, 1'b0);
      expect_rsp("R1 empty table misses kseg", F_MISS, 32'h0);
   endtask

   task automatic t_direct();
      lookup(32'h8012_3456, 6'd9, 2'b00, 1'b0);
      expect_rsp("R5 direct cached", F_HIT, 32'h0012_3456);
      lookup(32'hA0AB_CDEF, 6'd9, 2'b01, 1'b0);
      expect_rsp("R5 direct uncached", F_HITU, 32'h00AB_CDEF);
   endtask

   task automatic t_user_kseg();
      lookup(32'h8000_0000, 6'd0, 2'b00, 1'b1);
      expect_rsp("R7 user to direct region", F_AERR, 32'h0);
      lookup(32'hC000_1000, 6'd0, 2'b10, 1'b1);
      expect_rsp("R7 user to mapped kernel region", F_AERR, 32'h0);
   endtask

   task automatic t_user_hit();
      do_fill(6'd5, 20'h00400, 6'd3, 20'h12345, 4'b1110);
      lookup(32'h0040_0ABC, 6'd3, 2'b00, 1'b1);
      expect_rsp("R3 user read hit", F_HIT, 32'h1234_5ABC);
      lookup(32'h0040_0FFF, 6'd3, 2'b10, 1'b1);
      expect_rsp("R9 fetch hit", F_HIT, 32'h1234_5FFF);
      lookup(32'h0040_0000, 6'd3, 2'b01, 1'b1);
      expect_rsp("R9 write to writable page", F_HIT, 32'h1234_5000);
      lookup(32'h0040_0ABC, 6'd4, 2'b00, 1'b1);
      expect_rsp("R4 other identifier misses", F_MISS, 32'h0);
      lookup(32'h0041_0ABC, 6'd3, 2'b00, 1'b1);
      expect_rsp("R4 other page misses", F_MISS, 32'h0);
   endtask

   task automatic t_kmapped();
      do_fill(6'd63, 20'hC0001, 6'd0, 20'h00077, 4'b1001);
      lookup(32'hC000_1FFF, 6'd0, 2'b00, 1'b0);
      expect_rsp("R10 nocache entry", F_HITU, 32'h0007_7FFF);
      lookup(32'hC000_1010, 6'd0, 2'b01, 1'b0);
      expect_rsp("R9 write to read-only page", F_PROT, 32'h0);
      lookup(32'hC000_1010, 6'd0, 2'b11, 1'b0);
      expect_rsp("R9 kind 11 acts as read", F_HITU, 32'h0007_7010);
   endtask

   task automatic t_user_bit();
      do_fill(6'd10, 20'h00010, 6'd1, 20'h0ABCD, 4'b1100);
      lookup(32'h0001_0004, 6'd1, 2'b00, 1'b1);
      expect_rsp("R8 user to kernel page", F_AERR, 32'h0);
      lookup(32'h0001_0004, 6'd1, 2'b00, 1'b0);
      expect_rsp("R8 kernel to kernel page", F_HIT, 32'h0ABC_D004);
   endtask

   task automatic t_not_present();
      do_fill(6'd20, 20'h00020, 6'd2, 20'h0BEEF, 4'b0111);
      lookup(32'h0002_0000, 6'd2, 2'b00, 1'b0);
      expect_rsp("R6 absent entry misses", F_MISS, 32'h0);
   endtask

   task automatic t_fill_collide();
      @(negedge clk);
      fill_en = 1'b1; fill_idx = 6'd5; fill_vpn = 20'h00500; fill_asid = 6'd3;
      fill_pfn = 20'h55555;
      {fill_present, fill_writable, fill_user, fill_nocache} = 4'b1110;
      req_valid = 1'b1; req_va = 32'h0050_0010; req_asid = 6'd3; req_kind = 2'b00; req_user = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; fill_en = 1'b0;
      expect_rsp("R11 same-cycle lookup sees old", F_MISS, 32'h0);
      lookup(32'h0050_0010, 6'd3, 2'b00, 1'b1);
      expect_rsp("R11 new entry visible", F_HIT, 32'h5555_5010);
      lookup(32'h0040_0ABC, 6'd3, 2'b00, 1'b1);
      expect_rsp("R11 replaced entry gone", F_MISS, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_direct();
      t_user_kseg();
      t_user_hit();
      t_kmapped();
      t_user_bit();
      t_not_present();
      t_fill_collide();
      @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         vectors++;
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

endmodule